// File: doc/BRIEF.md
# Stimulation Frame and Artifact-Reset Controller

This controller sequences voltage-mode stimulation for an array of channels and the recording-amplifier reset that follows it. While the load input is high, samples arrive one at a time and are written into the per-channel hold stages in ascending channel order. Each write drives the selected channel's hold switches through a release sequence in which the bottom-plate switch opens one clock before the top switches, which limits charge injection.

An accepted fire pulse copies the whole stored frame to every channel's drive level in one clock. It also latches the channel enable mask and the pulse settings. The controller then runs a monophasic pulse, or a biphasic pair with an opposite-polarity second phase. Between the two phases of a biphasic pair there is a gap of at least one clock with neither polarity driven. Only enabled channels are powered and given polarity drive. The active-low amplifier reset is held low through the whole stimulation and for a programmed number of clocks afterwards. A fire pulse that arrives at a bad moment is dropped and sets a sticky error flag.

Top module: `stim_frame_ctrl`

## Requirements
- R1: With `loadIn` high, accepted samples go to channels 0, 1, 2, … in order. Dropping `loadIn` returns the write pointer to channel 0. Once all `NCH` channels are written, `loadReady` stays low and further samples are ignored.
- R2: A sample is accepted on a clock edge where `sampleValid` and `loadReady` are both high. In the next cycle, `holdSel` has the written channel's bit set (one-hot) and both `holdBotClosed` and `holdTopClosed` are 1. In the cycle after that, `holdBotClosed` is 0 and `holdTopClosed` is 1. In the third cycle, both are 0 and `holdSel` is 0. `loadReady` is low during the first two of these cycles.
- R3: An accepted fire copies every stored sample to `appliedFrame` on its capture edge, with channel i at bits [i*SW +: SW]. It also latches `maskIn` and the pulse settings. Later changes to these inputs do not alter the running pulse.
- R4: Let W = max(phaseWidthIn,1) and G = max(gapWidthIn,1).
  - The first phase starts the cycle after the capture edge and lasts W cycles. Its polarity is UP when `downFirstIn`=0 and DOWN when `downFirstIn`=1.
  - When `biphasicIn`=0, the pulse ends after the first phase.
  - When `biphasicIn`=1, G cycles with neither polarity follow, then W cycles of the opposite polarity.
- R5: `stimUp` and `stimDown` are never high together for any channel.
- R6: `stimPowerEn`, `stimUp` and `stimDown` are nonzero only on channels whose latched mask bit is 1. `stimPowerEn` is high on those channels from the first phase through the last phase, including the gap.
- R7: `ampResetN` is low from the first phase through resetHoldIn cycles after the last phase, and high at all other times.
- R8: A fire is dropped while `loadIn` is high, while a hold-switch sequence is running, or while a phase or gap is active. A dropped fire sets `errFlag`, which stays set until reset. A fire during the post-stimulation reset window is accepted.
- R9: After reset, all drive outputs, `holdSel` and `appliedFrame` are 0, `loadReady` and `errFlag` are 0, and `ampResetN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadIn | input | 1 | Frame load window; low rewinds the write pointer |
| sampleValid | input | 1 | A sample is offered on sampleIn |
| sampleIn | input | SW | Stimulation level for the next channel |
| loadReady | output | 1 | A sample can be accepted this cycle |
| maskIn | input | NCH | Channel enable mask, latched at fire |
| biphasicIn | input | 1 | 1 = biphasic pair, 0 = single phase |
| downFirstIn | input | 1 | 1 = first phase drives DOWN |
| phaseWidthIn | input | CW | Phase length in clocks (0 treated as 1) |
| gapWidthIn | input | CW | Inter-phase gap in clocks (0 treated as 1) |
| resetHoldIn | input | CW | Amplifier reset clocks after the last phase |
| fireIn | input | 1 | Fire request pulse |
| holdSel | output | NCH | One-hot channel whose hold switches are driven |
| holdBotClosed | output | 1 | Bottom-plate hold switch closed |
| holdTopClosed | output | 1 | Top hold switches closed |
| appliedFrame | output | NCH*SW | Levels applied to all channels |
| stimPowerEn | output | NCH | Per-channel stimulator power |
| stimUp | output | NCH | Per-channel positive polarity drive |
| stimDown | output | NCH | Per-channel negative polarity drive |
| ampResetN | output | 1 | Recording amplifier reset, active low |
| errFlag | output | 1 | Sticky dropped-fire flag |

## Verification
The embedded assertions check on every cycle the properties that are local in time:
- the two polarities are never driven together;
- the idle clock between phases;
- the bottom-before-top switch release order and the one-hot channel select;
- that no sample is written into a full frame;
- the stickiness of the error flag;
- that an accepted fire starts a phase with the amplifier held in reset.

Only the bench scenarios can show the properties that span whole sequences. These are:
- that the channel ordering and pointer rewind put each sample in the right channel;
- that the full frame lands on all channels at once;
- the exact phase, gap and reset-window lengths, including the zero-width cases;
- that mask and setting changes after fire are ignored;
- that fires in the post-stimulation window restart a pulse while fires during a load or a phase do not.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PH1,
    ST_GAP,
    ST_PH2,
    ST_POST
  } stimState_t;

  typedef enum logic [1:0] {
    LD_IDLE,
    LD_CHARGE,
    LD_RELEASE
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic wrSample;
    logic ptrClear;
    logic applyFrame;
    logic stimOn;
    logic driveUp;
    logic driveDown;
    logic botClosed;
    logic topClosed;
  } ctrlStrobe_t;

endpackage

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadIn,
  input  logic          sampleValid,
  input  logic          frameFull,
  input  logic          fireIn,
  input  logic          biphasicIn,
  input  logic          downFirstIn,
  input  logic [CW-1:0] phaseWidthIn,
  input  logic [CW-1:0] gapWidthIn,
  input  logic [CW-1:0] resetHoldIn,
  output ctrlStrobe_t   str,
  output logic          loadReady,
  output logic          ampResetN,
  output logic          errFlag
);

  loadState_t ldState;
  stimState_t state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] widthReg, gapReg, holdReg;
  logic biReg, downFirstReg;

  logic loadBusy, acceptSample, pulseActive, fireBlocked, fireOk, fireBad;

  function automatic logic [CW-1:0] dec1(input logic [CW-1:0] x);
    return (x == '0) ? '0 : x - CW'(1);
  endfunction

  assign loadBusy     = (ldState != LD_IDLE);
  assign loadReady    = loadIn && !loadBusy && !frameFull;
  assign acceptSample = loadReady && sampleValid;
  assign pulseActive  = (state == ST_PH1) || (state == ST_GAP) || (state == ST_PH2);
  assign fireBlocked  = loadIn || loadBusy || pulseActive;
  assign fireOk       = fireIn && !fireBlocked;
  assign fireBad      = fireIn && fireBlocked;

  // hold-switch release sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ldState <= LD_IDLE;
    end else begin
      unique case (ldState)
        LD_IDLE:    if (acceptSample) ldState <= LD_CHARGE;
        LD_CHARGE:  ldState <= LD_RELEASE;
        LD_RELEASE: ldState <= LD_IDLE;
        default:    ldState <= LD_IDLE;
      endcase
    end
  end

  // stimulation sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      widthReg     <= '0;
      gapReg       <= '0;
      holdReg      <= '0;
      biReg        <= 1'b0;
      downFirstReg <= 1'b0;
    end else if (fireOk) begin
      state        <= ST_PH1;
      cnt          <= dec1(phaseWidthIn);
      widthReg     <= phaseWidthIn;
      gapReg       <= gapWidthIn;
      holdReg      <= resetHoldIn;
      biReg        <= biphasicIn;
      downFirstReg <= downFirstIn;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_PH1: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (biReg) begin
            state <= ST_GAP;
            cnt   <= dec1(gapReg);
          end else if (holdReg == '0) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_POST;
            cnt   <= holdReg - CW'(1);
          end
        end
        ST_GAP: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else begin
            state <= ST_PH2;
            cnt   <= dec1(widthReg);
          end
        end
        ST_PH2: begin
          if (cnt != '0) begin
            cnt <= cnt - CW'(1);
          end else if (holdReg == '0) begin
            state <= ST_IDLE;
          end else begin
            state <= ST_POST;
            cnt   <= holdReg - CW'(1);
          end
        end
        ST_POST: begin
          if (cnt != '0) cnt <= cnt - CW'(1);
          else           state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        errFlag <= 1'b0;
    else if (fireBad) errFlag <= 1'b1;
  end

  always_comb begin
    str            = '0;
    str.wrSample   = acceptSample;
    str.ptrClear   = !loadIn;
    str.applyFrame = fireOk;
    str.stimOn     = pulseActive;
    str.driveUp    = ((state == ST_PH1) && !downFirstReg) || ((state == ST_PH2) && downFirstReg);
    str.driveDown  = ((state == ST_PH1) && downFirstReg) || ((state == ST_PH2) && !downFirstReg);
    str.botClosed  = (ldState == LD_CHARGE);
    str.topClosed  = (ldState == LD_CHARGE) || (ldState == LD_RELEASE);
  end

  assign ampResetN = (state == ST_IDLE);

  // R5: the two polarities never overlap
  p_updown_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(str.driveUp && str.driveDown));

  // R4: a clock with no drive separates the phases
  p_gap_after_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(str.driveUp) |-> !str.driveDown);
  p_gap_after_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(str.driveDown) |-> !str.driveUp);

  // R2: the bottom plate releases before the top switches
  p_bot_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    str.botClosed |=> (str.topClosed && !str.botClosed));
  p_top_last_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(str.topClosed) |-> !$past(str.botClosed));

  // R3 / R7: an accepted fire starts a phase with the amplifier in reset
  p_fire_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    fireOk |=> (str.stimOn && !ampResetN));

  // R8: a dropped fire sets a flag that stays set
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    fireBad |=> errFlag);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

endmodule

// File: rtl/sfc_dp.sv
module sfc_dp
  import sfc_pkg::*;
#(
  parameter int NCH = 128,
  parameter int SW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       str,
  input  logic [SW-1:0]     sampleIn,
  input  logic [NCH-1:0]    maskIn,
  output logic              frameFull,
  output logic [NCH-1:0]    holdSel,
  output logic [NCH*SW-1:0] appliedFrame,
  output logic [NCH-1:0]    stimPowerEn,
  output logic [NCH-1:0]    stimUp,
  output logic [NCH-1:0]    stimDown
);

  localparam int PW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PW:0]    ptr;
  logic [PW-1:0]  curCh;
  logic [NCH-1:0] maskReg;

  assign frameFull = (ptr == (PW+1)'(NCH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr   <= '0;
      curCh <= '0;
    end else if (str.ptrClear) begin
      ptr <= '0;
    end else if (str.wrSample) begin
      ptr   <= ptr + (PW+1)'(1);
      curCh <= ptr[PW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskReg <= '0;
    else if (str.applyFrame) maskReg <= maskIn;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [SW-1:0] holdVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        holdVal <= '0;
      else if (str.wrSample && (ptr == (PW+1)'(i)))
        holdVal <= sampleIn;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               appliedFrame[i*SW +: SW] <= '0;
      else if (str.applyFrame) appliedFrame[i*SW +: SW] <= holdVal;
    end

    assign holdSel[i]     = str.topClosed && (curCh == PW'(i));
    assign stimPowerEn[i] = maskReg[i] && str.stimOn;
    assign stimUp[i]      = maskReg[i] && str.driveUp;
    assign stimDown[i]    = maskReg[i] && str.driveDown;
  end

  // R2: at most one channel's switches are driven
  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(holdSel));

  // R1: a full frame takes no more samples
  p_no_write_full_r1: assert property (@(posedge clk) disable iff (!rstN)
    frameFull |-> !str.wrSample);
  p_ptr_bound_r1: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= (PW+1)'(NCH));

  // R6: no drive reaches a channel without power
  p_drive_needs_power_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((stimUp | stimDown) & ~stimPowerEn) == '0);

endmodule

// File: rtl/stim_frame_ctrl.sv
module stim_frame_ctrl
  import sfc_pkg::*;
#(
  parameter int NCH = 128,
  parameter int SW  = 8,
  parameter int CW  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadIn,
  input  logic              sampleValid,
  input  logic [SW-1:0]     sampleIn,
  output logic              loadReady,
  input  logic [NCH-1:0]    maskIn,
  input  logic              biphasicIn,
  input  logic              downFirstIn,
  input  logic [CW-1:0]     phaseWidthIn,
  input  logic [CW-1:0]     gapWidthIn,
  input  logic [CW-1:0]     resetHoldIn,
  input  logic              fireIn,
  output logic [NCH-1:0]    holdSel,
  output logic              holdBotClosed,
  output logic              holdTopClosed,
  output logic [NCH*SW-1:0] appliedFrame,
  output logic [NCH-1:0]    stimPowerEn,
  output logic [NCH-1:0]    stimUp,
  output logic [NCH-1:0]    stimDown,
  output logic              ampResetN,
  output logic              errFlag
);

  ctrlStrobe_t str;
  logic frameFull;

  sfc_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadIn(loadIn), .sampleValid(sampleValid),
    .frameFull(frameFull), .fireIn(fireIn), .biphasicIn(biphasicIn),
    .downFirstIn(downFirstIn), .phaseWidthIn(phaseWidthIn),
    .gapWidthIn(gapWidthIn), .resetHoldIn(resetHoldIn), .str(str),
    .loadReady(loadReady), .ampResetN(ampResetN), .errFlag(errFlag)
  );

  sfc_dp #(.NCH(NCH), .SW(SW)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .sampleIn(sampleIn), .maskIn(maskIn),
    .frameFull(frameFull), .holdSel(holdSel), .appliedFrame(appliedFrame),
    .stimPowerEn(stimPowerEn), .stimUp(stimUp), .stimDown(stimDown)
  );

  assign holdBotClosed = str.botClosed;
  assign holdTopClosed = str.topClosed;

endmodule

// File: tb/tb_stim_frame_ctrl.sv
module tb_stim_frame_ctrl;

  localparam int NCH = 128;
  localparam int SW  = 8;
  localparam int CW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadIn = 1'b0, sampleValid = 1'b0, biphasicIn = 1'b0, downFirstIn = 1'b0, fireIn = 1'b0;
  logic [SW-1:0]  sampleIn = '0;
  logic [NCH-1:0] maskIn = '0;
  logic [CW-1:0]  phaseWidthIn = '0, gapWidthIn = '0, resetHoldIn = '0;
  logic loadReady, holdBotClosed, holdTopClosed, ampResetN, errFlag;
  logic [NCH-1:0] holdSel, stimPowerEn, stimUp, stimDown;
  logic [NCH*SW-1:0] appliedFrame;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;
  logic [SW-1:0] expFrame [NCH];
  int expPtr = 0;

  stim_frame_ctrl #(.NCH(NCH), .SW(SW), .CW(CW)) dut (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int maxOne(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  task automatic doReset();
    rstN = 1'b0; loadIn = 0; sampleValid = 0; fireIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < NCH; i++) expFrame[i] = '0;
    expPtr = 0;
    @(negedge clk);
  endtask

  task automatic checkFrame(input string req);
    int bad = 0;
    int firstBad = -1;
    for (int i = 0; i < NCH; i++)
      if (appliedFrame[i*SW +: SW] !== expFrame[i]) begin
        bad++;
        if (firstBad < 0) firstBad = i;
      end
    chk(bad == 0, req, "applied frame mismatching channels (first index)", bad, 0);
    if (firstBad >= 0)
      $display("  first mismatch channel %0d", firstBad);
  endtask

  // write n samples; loadIn is left high
  task automatic loadSamples(input int n);
    int seqBad = 0;
    loadIn = 1'b1;
    @(negedge clk);
    for (int s = 0; s < n; s++) begin
      logic [SW-1:0] v;
      v = SW'($urandom);
      sampleValid = 1'b1;
      sampleIn = v;
      @(negedge clk);
      sampleValid = 1'b0;
      if (holdSel !== (NCH'(1) << expPtr) || !holdBotClosed || !holdTopClosed || loadReady)
        seqBad++;
      @(negedge clk);
      if (holdSel !== (NCH'(1) << expPtr) || holdBotClosed || !holdTopClosed || loadReady)
        seqBad++;
      @(negedge clk);
      if (holdSel !== '0 || holdTopClosed || holdBotClosed)
        seqBad++;
      expFrame[expPtr] = v;
      expPtr++;
      if (loadReady !== (expPtr < NCH)) seqBad++;
    end
    chk(seqBad == 0, "R2", "hold switch sequence faults", seqBad, 0);
  endtask

  task automatic endLoad();
    loadIn = 1'b0;
    expPtr = 0;
    repeat (2) @(negedge clk);
  endtask

  // fire and compare every cycle of the pulse with the expected timing
  task automatic runPulse(input int w, input int g, input int r, input bit bi,
                          input bit dn, input logic [NCH-1:0] mask);
    int w1, g1, e;
    int badUp = 0, badDn = 0, badPw = 0, badRs = 0;
    w1 = maxOne(w); g1 = maxOne(g);
    e = bi ? (2*w1 + g1) : w1;
    phaseWidthIn = CW'(w); gapWidthIn = CW'(g); resetHoldIn = CW'(r);
    biphasicIn = bi; downFirstIn = dn; maskIn = mask;
    fireIn = 1'b1;
    @(negedge clk);
    fireIn = 1'b0;
    // later changes must not matter (R3)
    maskIn = ~mask; biphasicIn = ~bi; downFirstIn = ~dn;
    phaseWidthIn = CW'(w + 3); resetHoldIn = '0;
    checkFrame("R3");
    for (int k = 0; k < e + r + 3; k++) begin
      bit eUp, eDn, ePw, eRs;
      bit ph1, ph2;
      ph1 = (k < w1);
      ph2 = bi && (k >= w1 + g1) && (k < e);
      eUp = (ph1 && !dn) || (ph2 && dn);
      eDn = (ph1 && dn) || (ph2 && !dn);
      ePw = (k < e);
      eRs = !(k < e + r);
      if (stimUp !== (eUp ? mask : '0)) badUp++;
      if (stimDown !== (eDn ? mask : '0)) badDn++;
      if (stimPowerEn !== (ePw ? mask : '0)) badPw++;
      if (ampResetN !== eRs) badRs++;
      @(negedge clk);
    end
    chk(badUp == 0, "R4", "cycles with wrong UP drive", badUp, 0);
    chk(badDn == 0, "R4", "cycles with wrong DOWN drive", badDn, 0);
    chk(badPw == 0, "R6", "cycles with wrong power enable", badPw, 0);
    chk(badRs == 0, "R7", "cycles with wrong amplifier reset", badRs, 0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    // R9 reset state
    chk(loadReady === 1'b0 && errFlag === 1'b0 && ampResetN === 1'b1, "R9",
        "reset flags (ready,err,resetN)", {loadReady, errFlag, ampResetN}, 3'b001);
    chk(stimUp === '0 && stimDown === '0 && stimPowerEn === '0 && holdSel === '0, "R9",
        "reset drive outputs nonzero", 1, 0);
    chk(appliedFrame === '0, "R9", "reset applied frame nonzero", 1, 0);
    doReset();

    // R1: full frame, then overfill attempt
    loadSamples(NCH);
    chk(loadReady === 1'b0, "R1", "ready after full frame", loadReady, 0);
    sampleValid = 1'b1; sampleIn = 8'hA5;
    repeat (2) @(negedge clk);
    sampleValid = 1'b0;
    chk(holdTopClosed === 1'b0, "R1", "switches moved on full frame", holdTopClosed, 0);
    endLoad();
    runPulse(3, 2, 4, 1'b1, 1'b0, {NCH{1'b1}});

    // R1: pointer rewinds, only channels 0..2 change
    loadSamples(3);
    endLoad();
    runPulse(2, 0, 0, 1'b0, 1'b1, {64'h0, 64'hF0F0_0000_0000_00FF});

    // directed zero widths, biphasic DOWN first (R4)
    runPulse(0, 0, 0, 1'b1, 1'b1, {NCH{1'b1}});
    // empty mask: nothing powered (R6)
    runPulse(4, 1, 2, 1'b1, 1'b0, '0);

    // constrained random pulses
    for (int it = 0; it < 10; it++) begin
      logic [NCH-1:0] m;
      m = {$urandom, $urandom, $urandom, $urandom};
      runPulse(int'($urandom % 6), int'($urandom % 4), int'($urandom % 8),
               1'($urandom), 1'($urandom), m);
    end

    // R8: fire in post-reset window is accepted
    phaseWidthIn = 2; gapWidthIn = 0; resetHoldIn = 10; biphasicIn = 0;
    downFirstIn = 0; maskIn = {NCH{1'b1}};
    fireIn = 1; @(negedge clk); fireIn = 0;
    repeat (4) @(negedge clk);
    chk(ampResetN === 1'b0 && stimUp === '0, "R7", "post window state", ampResetN, 0);
    fireIn = 1; @(negedge clk); fireIn = 0;
    chk(stimUp === {NCH{1'b1}} && errFlag === 1'b0, "R8",
        "refire in post window (err)", errFlag, 0);
    repeat (16) @(negedge clk);

    // R8: fire during a phase is dropped
    phaseWidthIn = 6; resetHoldIn = 0;
    fireIn = 1; @(negedge clk); fireIn = 0;
    repeat (2) @(negedge clk);
    fireIn = 1; @(negedge clk); fireIn = 0;
    chk(errFlag === 1'b1, "R8", "err after fire in phase", errFlag, 1);
    repeat (3) @(negedge clk);
    chk(stimUp === '0 && ampResetN === 1'b1, "R8", "pulse not extended (resetN)", ampResetN, 1);
    repeat (4) @(negedge clk);
    chk(errFlag === 1'b1, "R8", "err sticky", errFlag, 1);

    // R8: fire during a load is dropped
    doReset();
    chk(errFlag === 1'b0, "R8", "err cleared by reset", errFlag, 0);
    loadIn = 1; phaseWidthIn = 3;
    @(negedge clk);
    fireIn = 1; @(negedge clk); fireIn = 0;
    chk(errFlag === 1'b1, "R8", "err after fire during load", errFlag, 1);
    chk(stimPowerEn === '0 && ampResetN === 1'b1, "R8", "no pulse during load", ampResetN, 1);
    loadIn = 0;
    repeat (2) @(negedge clk);

    // R8: fire during switch sequence (load just dropped)
    doReset();
    loadSamples(1);
    loadIn = 0;
    sampleValid = 1; sampleIn = 8'h3C; loadIn = 1;
    @(negedge clk);
    sampleValid = 0; loadIn = 0;
    fireIn = 1; @(negedge clk); fireIn = 0;
    chk(errFlag === 1'b1, "R8", "err after fire during switch sequence", errFlag, 1);
    repeat (3) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nErr++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule